// File: doc/BRIEF.md
# Set/Clear Interrupt Event Aggregator

This block collects interrupt events for a host-visible controller and turns them into one level interrupt. Software reaches every control register through a pair of write addresses: one address sets the bits written as 1, and the other clears them. Bits written as 0 keep their value, so software never needs a read-modify-write. A read from either address of a pair returns the current contents.

The block holds a main event register and a main mask register. It also holds an event register and a mask register for four isochronous transmit contexts and for four isochronous receive contexts. Each context's completion pulse sets its own event bit. The masked OR of each context bank feeds a read-only summary bit in the main event register: bit 6 for transmit and bit 7 for receive. The interrupt pin is driven when main mask bit 31 (the master enable) is set and any unmasked main event bit in positions 30..0 is set. Bit 30 is a general vendor source with its own enable bit, in the same way as every other position.

Top module: `irq_agg_top`

## Requirements
- R1: A write of data D to the set address of a register ORs D into that register. For a context register only the low 4 bits apply.
- R2: A write of data D to the clear address of a register clears every bit where D is 1. All other bits keep their value.
- R3: Both addresses of a pair read back the same current contents. `rd_data` is combinational from `rd_addr`.
- R4: A pulse on `tx_done[i]` sets transmit event bit i. A pulse on `rx_done[i]` sets receive event bit i. A pulse on `hw_evt[b]` sets main event bit b.
- R5: Main event bit 6 reads as the OR of (transmit event AND transmit mask), and bit 7 reads as the same OR for the receive bank. Software writes and `hw_evt` pulses at bits 6 and 7 have no effect on those bits.
- R6: `irq` is registered. It equals main mask bit 31 AND the OR over bits 30..0 of (main event read value AND main mask). It changes one cycle after the state it depends on.
- R7: When a hardware pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R8: Synchronous active-high `rst` clears every register and `irq`.
- R9: The address is {index[2:0], clr}, with clr=1 selecting the clear address. The indices are: 0 main event, 1 main mask, 2 transmit event, 3 transmit mask, 4 receive event, 5 receive mask. Indices 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address {index, clr} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address {index, clr} |
| rd_data | output | 32 | Read data of the addressed register |
| hw_evt | input | 32 | Hardware event pulses for the main event register |
| tx_done | input | 4 | Transmit context completion pulses |
| rx_done | input | 4 | Receive context completion pulses |
| irq | output | 1 | Level interrupt output |

## Verification
A long pseudo-random sweep mixes set writes, clear writes and writes to the unused indices with sparse hardware and context pulses. After every operation all sixteen read addresses and the interrupt pin are compared with an arithmetic model. This separates a correct set/clear decode from swapped or leaky decodes, and a correct summary from one that ignores a mask. Directed patterns follow. A same-cycle pulse against a clear exposes the wrong priority. Writes at bits 6 and 7 expose a summary that can be written. Toggling the master enable with pending events exposes a gate that is missing.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_TX     = 4;
    localparam int NUM_RX     = 4;
    localparam int ADDR_W     = 4;
    localparam int SUM_TX_BIT = 6;
    localparam int SUM_RX_BIT = 7;
    localparam int MASTER_BIT = 31;

    typedef enum logic [2:0] {
        IDX_MAIN_EVT = 3'd0,
        IDX_MAIN_MSK = 3'd1,
        IDX_TX_EVT   = 3'd2,
        IDX_TX_MSK   = 3'd3,
        IDX_RX_EVT   = 3'd4,
        IDX_RX_MSK   = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic       en;
        logic [2:0] idx;
        logic       clr;
    } wr_dec_t;

    localparam logic [DATA_W-1:0] MAIN_RO_MASK =
        (DATA_W'(1) << SUM_TX_BIT) | (DATA_W'(1) << SUM_RX_BIT);

    function automatic wr_dec_t decode_wr(input logic en, input logic [ADDR_W-1:0] a);
        wr_dec_t d;
        d.en  = en;
        d.idx = a[ADDR_W-1:1];
        d.clr = a[0];
        return d;
    endfunction

    function automatic logic hits_set(input wr_dec_t d, input reg_idx_e k);
        return d.en && (d.idx == k) && !d.clr;
    endfunction

    function automatic logic hits_clr(input wr_dec_t d, input reg_idx_e k);
        return d.en && (d.idx == k) && d.clr;
    endfunction
endpackage

// File: rtl/sc_reg_pair.sv
module sc_reg_pair #(
    parameter int              W       = 32,
    parameter logic [W-1:0]    RO_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] set_bits, clr_bits, nxt;

    always_comb begin
        set_bits = set_we ? wdata : '0;
        clr_bits = clr_we ? wdata : '0;
        nxt      = (((q | set_bits) & ~clr_bits) | hw_set) & ~RO_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R7: a hardware pulse always leaves its bit set
    p_hw_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (|(hw_set & ~RO_MASK)) |=> ((q & $past(hw_set & ~RO_MASK)) == $past(hw_set & ~RO_MASK)));

    // R1: set write leaves written ones set
    p_set_r1: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((q & $past(wdata & ~RO_MASK)) == $past(wdata & ~RO_MASK)));

    // R2: clear write clears written ones unless a pulse hits the bit
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((q & $past(wdata & ~hw_set)) == '0));
endmodule

// File: rtl/ctx_bank.sv
module ctx_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt_set_we,
    input  logic         evt_clr_we,
    input  logic         msk_set_we,
    input  logic         msk_clr_we,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] done,
    output logic [N-1:0] evt_q,
    output logic [N-1:0] msk_q,
    output logic         summary
);
    sc_reg_pair #(.W(N), .RO_MASK('0)) u_evt (
        .clk(clk), .rst(rst), .set_we(evt_set_we), .clr_we(evt_clr_we),
        .wdata(wdata), .hw_set(done), .q(evt_q)
    );

    sc_reg_pair #(.W(N), .RO_MASK('0)) u_msk (
        .clk(clk), .rst(rst), .set_we(msk_set_we), .clr_we(msk_clr_we),
        .wdata(wdata), .hw_set('0), .q(msk_q)
    );

    logic [N-1:0] gated;
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_gate
            assign gated[g] = evt_q[g] & msk_q[g];
        end
    endgenerate
    assign summary = |gated;

    // R5: an empty bank never raises its summary
    p_summary_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (evt_q == '0) |-> !summary);
    // R4: a completion pulse lands in the event register
    p_done_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (|done) |=> ((evt_q & $past(done)) == $past(done)));
endmodule

// File: rtl/irq_out.sv
module irq_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-2:0] evt_low,
    input  logic [W-1:0] msk,
    output logic         irq
);
    logic pending;
    assign pending = |(evt_low & msk[W-2:0]);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= msk[W-1] & pending;
    end

    // R6: irq only follows a cycle in which the master enable was set
    p_master_gate_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(msk[W-1]));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] hw_evt,
    input  logic [NUM_TX-1:0] tx_done,
    input  logic [NUM_RX-1:0] rx_done,
    output logic              irq
);
    wr_dec_t dec;
    assign dec = decode_wr(wr_en, wr_addr);

    logic [DATA_W-1:0] main_evt_q, main_msk_q, main_evt_rd;
    logic [NUM_TX-1:0] tx_evt_q, tx_msk_q;
    logic [NUM_RX-1:0] rx_evt_q, rx_msk_q;
    logic              tx_sum, rx_sum;

    sc_reg_pair #(.W(DATA_W), .RO_MASK(MAIN_RO_MASK)) u_main_evt (
        .clk(clk), .rst(rst),
        .set_we(hits_set(dec, IDX_MAIN_EVT)), .clr_we(hits_clr(dec, IDX_MAIN_EVT)),
        .wdata(wr_data), .hw_set(hw_evt), .q(main_evt_q)
    );

    sc_reg_pair #(.W(DATA_W), .RO_MASK('0)) u_main_msk (
        .clk(clk), .rst(rst),
        .set_we(hits_set(dec, IDX_MAIN_MSK)), .clr_we(hits_clr(dec, IDX_MAIN_MSK)),
        .wdata(wr_data), .hw_set('0), .q(main_msk_q)
    );

    ctx_bank #(.N(NUM_TX)) u_tx (
        .clk(clk), .rst(rst),
        .evt_set_we(hits_set(dec, IDX_TX_EVT)), .evt_clr_we(hits_clr(dec, IDX_TX_EVT)),
        .msk_set_we(hits_set(dec, IDX_TX_MSK)), .msk_clr_we(hits_clr(dec, IDX_TX_MSK)),
        .wdata(wr_data[NUM_TX-1:0]), .done(tx_done),
        .evt_q(tx_evt_q), .msk_q(tx_msk_q), .summary(tx_sum)
    );

    ctx_bank #(.N(NUM_RX)) u_rx (
        .clk(clk), .rst(rst),
        .evt_set_we(hits_set(dec, IDX_RX_EVT)), .evt_clr_we(hits_clr(dec, IDX_RX_EVT)),
        .msk_set_we(hits_set(dec, IDX_RX_MSK)), .msk_clr_we(hits_clr(dec, IDX_RX_MSK)),
        .wdata(wr_data[NUM_RX-1:0]), .done(rx_done),
        .evt_q(rx_evt_q), .msk_q(rx_msk_q), .summary(rx_sum)
    );

    always_comb begin
        main_evt_rd = main_evt_q;
        main_evt_rd[SUM_TX_BIT] = tx_sum;
        main_evt_rd[SUM_RX_BIT] = rx_sum;
    end

    always_comb begin
        unique case (rd_addr[ADDR_W-1:1])
            IDX_MAIN_EVT: rd_data = main_evt_rd;
            IDX_MAIN_MSK: rd_data = main_msk_q;
            IDX_TX_EVT:   rd_data = DATA_W'(tx_evt_q);
            IDX_TX_MSK:   rd_data = DATA_W'(tx_msk_q);
            IDX_RX_EVT:   rd_data = DATA_W'(rx_evt_q);
            IDX_RX_MSK:   rd_data = DATA_W'(rx_msk_q);
            default:      rd_data = '0;
        endcase
    end

    irq_out #(.W(DATA_W)) u_irq (
        .clk(clk), .rst(rst),
        .evt_low(main_evt_rd[DATA_W-2:0]), .msk(main_msk_q), .irq(irq)
    );

    // R5: software cannot store a value in the summary positions
    p_summary_ro_r5: assert property (@(posedge clk) disable iff (rst)
        (main_evt_q[SUM_TX_BIT] == 1'b0) && (main_evt_q[SUM_RX_BIT] == 1'b0));
endmodule

// File: tb/irq_agg_top_bench.sv
`timescale 1ns/1ps
module irq_agg_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] hw_evt = '0;
    logic [3:0]  tx_done = '0;
    logic [3:0]  rx_done = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [31:0] m [0:5];
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    irq_agg_top u_irq_agg_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .hw_evt(hw_evt),
        .tx_done(tx_done), .rx_done(rx_done), .irq(irq)
    );

    function automatic logic [31:0] nxt_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic rnd(output logic [31:0] v);
        seed = nxt_rand(seed);
        v = seed;
    endtask

    function automatic logic [31:0] exp_rd(input int idx);
        logic ts, rs;
        ts = |(m[2][3:0] & m[3][3:0]);
        rs = |(m[4][3:0] & m[5][3:0]);
        if (idx == 0) return m[0] | (32'(ts) << 6) | (32'(rs) << 7);
        if (idx < 6)  return m[idx];
        return 32'h0;
    endfunction

    function automatic logic exp_irq();
        logic [31:0] e = exp_rd(0);
        return m[1][31] & (|(e[30:0] & m[1][30:0]));
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #0.2;
            if (a / 2 >= 6)      chk({tag, " R9 unused read"}, rd_data, 32'h0);
            else if (a / 2 == 0) chk({tag, " R5 main event read"}, rd_data, exp_rd(0));
            else if (a % 2 == 1) chk({tag, " R3 clear-address read"}, rd_data, exp_rd(a / 2));
            else                 chk({tag, " R1 set-address read"}, rd_data, exp_rd(a / 2));
        end
        chk({tag, " R6 irq"}, 32'(irq), 32'(exp_irq()));
    endtask

    task automatic step(input logic en, input logic [3:0] a, input logic [31:0] d,
                        input logic [31:0] hw, input logic [3:0] tx, input logic [3:0] rx);
        int idx;
        logic [31:0] dm;
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; hw_evt = hw; tx_done = tx; rx_done = rx;
        idx = int'(a[3:1]);
        if (en && idx < 6) begin
            dm = (idx == 0) ? (d & ~32'hC0) : (idx == 1) ? d : (d & 32'hF);
            if (a[0]) m[idx] = m[idx] & ~dm;
            else      m[idx] = m[idx] | dm;
        end
        m[0] = m[0] | (hw & ~32'hC0);
        m[2] = m[2] | 32'(tx);
        m[4] = m[4] | 32'(rx);
        @(negedge clk);
        wr_en = 1'b0; hw_evt = '0; tx_done = '0; rx_done = '0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R8 reset");

        // R7: same-cycle pulse and clear on main bit 3 and tx bit 0
        step(1'b1, 4'd0, 32'h0000_0009, 32'h0, 4'h0, 4'h0);
        step(1'b1, 4'd1, 32'h0000_0009, 32'h8, 4'h0, 4'h0);
        chk("R7 main bit3 kept", 32'(m[0][3]), 32'h1);
        check_all("R7");
        step(1'b1, 4'd4, 32'h1, 32'h0, 4'h1, 4'h0);
        step(1'b1, 4'd5, 32'h1, 32'h0, 4'h1, 4'h0);
        check_all("R7 ctx");

        // R2: clear with no pulse
        step(1'b1, 4'd1, 32'h0000_0001, 32'h0, 4'h0, 4'h0);
        check_all("R2");

        // R5: writes and pulses at bits 6/7 ignored, summary from bank
        step(1'b1, 4'd0, 32'h0000_00C0, 32'hC0, 4'h0, 4'h0);
        check_all("R5 ignored");
        step(1'b1, 4'd6, 32'h1, 32'h0, 4'h0, 4'h0);
        step(1'b1, 4'd2, 32'h80C0_0040, 32'h0, 4'h0, 4'h0);
        check_all("R5 tx summary");
        step(1'b1, 4'd2, 32'h8000_0000, 32'h0, 4'h0, 4'h0);
        check_all("R6 master on");

        // R4: receive pulse with mask set
        step(1'b1, 4'd10, 32'h4, 32'h0, 4'h0, 4'h4);
        check_all("R4 rx");
        step(1'b1, 4'd3, 32'h8000_0000, 32'h0, 4'h0, 4'h0);
        check_all("R6 master off");

        // R9: writes to unused indices
        step(1'b1, 4'd12, 32'hFFFF_FFFF, 32'h0, 4'h0, 4'h0);
        step(1'b1, 4'd15, 32'hFFFF_FFFF, 32'h0, 4'h0, 4'h0);
        check_all("R9 unused write");

        // sweep
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r1, r2, r3, r4;
            rnd(r1); rnd(r2); rnd(r3); rnd(r4);
            step(r1[0] | r1[1], r1[7:4], r2,
                 (r3[2:0] == 0) ? (32'h1 << r3[8:4]) : 32'h0,
                 (r4[1:0] == 0) ? r4[7:4] : 4'h0,
                 (r4[9:8] == 0) ? r4[15:12] : 4'h0);
            check_all("sweep");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        bad++;
        total++;
        $display("FAIL watchdog R6: got hang expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule